// File: doc/BRIEF.md
# Serial GPIO Target Frame Receiver

This block sits on the target side of a three-wire serial status link of the kind a storage backplane uses to report drive-bay state. The initiator drives a serial clock, a load line that marks frame boundaries, and a serial data line toward the target. The target answers on a fourth line. The block works in its own system clock domain. It brings the three incoming wires through two-stage synchronizers and finds serial clock edges by oversampling them.

Each frame is either 12 or 24 bits long, chosen at run time. The 12-bit frame carries three status bits for each of four drives, and the 24-bit frame carries three bits for each of eight drives. Completed frames are stored in a small receive FIFO that software reads. A frame cut short by an early load edge is stored with zeros in its unused upper bits and raises a sticky flag. At every frame start the block takes one word from a transmit FIFO and shifts it out on the answer line, least significant bit first. It sends zeros when that FIFO is empty.

A measurement counter counts serial clocks between consecutive load edges. It reports the measured length so that software can learn the initiator's frame size before choosing the configured size.

Top module: `sgp_target_rx`

## Requirements
- R1: While reset is asserted, and after it is released with `en_i` low, `rx_empty_o`=1, `rx_full_o`=0, `meas_valid_o`=0, `short_o`=0, `ovf_o`=0 and `ser_din_o`=0.
- R2: `cfg_long_i`=0 selects 12-bit frames and `cfg_long_i`=1 selects 24-bit frames. A frame is written to the receive FIFO on the serial clock rising edge that delivers its last configured bit.
- R3: The load line and the data line are sampled on serial clock rising edges. A frame starts at a rising edge where the load line is high and was low at the previous rising edge. The data bit sampled at that edge is stored at bit 0, and the bit sampled at the k-th following rising edge is stored at bit k.
- R4: At each frame start after the first one since enable, `meas_len_o` takes the number of serial clock rising edges from the previous frame start to this one, and `meas_valid_o` rises and stays high while enabled.
- R5: Every stored word holds zeros above the bits received. A full 12-bit frame has bits 23..12 clear, and a 12-bit frame received with the 24-bit size configured is stored as its 12 bits with zeros above.
- R6: A frame start that arrives before the current frame reached its configured length stores the partial frame zero-padded and sets `short_o`, which stays set while enabled.
- R7: A frame that completes while the receive FIFO holds 4 words is discarded, the stored words are kept, and `ovf_o` is set and stays set while enabled.
- R8: The receive FIFO holds 4 words in arrival order. `rx_data_o` shows the oldest word, a cycle with `rx_rd_i`=1 removes it, and `rx_empty_o` and `rx_full_o` report 0 and 4 stored words.
- R9: At each frame start one word is taken from the transmit FIFO. Its bit k appears on `ser_din_o` after the serial clock falling edge that follows the k-th rising edge after the frame start (bit 0 follows the frame-start edge). After the configured number of bits, `ser_din_o` is 0.
- R10: If the transmit FIFO is empty at a frame start, `ser_din_o` stays 0 for that whole frame.
- R11: With `en_i`=0, the measurement, both sticky flags and the frame state are cleared, `ser_din_o` is 0, and serial activity stores nothing.
- R12: Bits that arrive after a frame reached its configured length and before the next frame start are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Receiver enable; low clears frame state and flags |
| cfg_long_i | input | 1 | Frame size select: 0 = 12 bits, 1 = 24 bits |
| ser_clk_i | input | 1 | Serial clock from the initiator (asynchronous) |
| ser_load_i | input | 1 | Load / frame-start line from the initiator (asynchronous) |
| ser_dout_i | input | 1 | Serial data from the initiator (asynchronous) |
| ser_din_o | output | 1 | Serial data to the initiator |
| rx_rd_i | input | 1 | Remove the oldest received word |
| rx_data_o | output | FRAME_W | Oldest received word |
| rx_empty_o | output | 1 | Receive FIFO holds no word |
| rx_full_o | output | 1 | Receive FIFO holds RX_DEPTH words |
| tx_wr_i | input | 1 | Write a word into the transmit FIFO |
| tx_data_i | input | FRAME_W | Word to transmit |
| tx_full_o | output | 1 | Transmit FIFO holds TX_DEPTH words |
| meas_len_o | output | LEN_W | Measured serial clocks between frame starts |
| meas_valid_o | output | 1 | Measured length is valid |
| short_o | output | 1 | Sticky: a short frame was stored |
| ovf_o | output | 1 | Sticky: a frame was dropped on a full FIFO |

## Verification
The assertions watch properties that must hold on every cycle. A word never enters a full receive FIFO. The overflow, short-frame and valid-length flags stay set until disable. Words stored in 12-bit mode keep their upper half clear. A disabled receiver has its flags and answer line at zero. Bit ordering, the measured frame length, the drop-on-full behaviour, the surplus bits after a complete frame and the bit-by-bit timing of the answer line depend on whole serial sequences, so only the bench scenarios can show them. Those scenarios are compared against a behavioural model.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

  // Frame size selection
  typedef enum logic {
    FRM_SHORT = 1'b0,
    FRM_LONG  = 1'b1
  } frm_sel_e;

  // One synchronized sample of the serial link inputs
  typedef struct packed {
    logic sck;
    logic ld;
    logic dat;
  } ser_smp_t;

endpackage

// File: rtl/sgp_sync.sv
module sgp_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] stg_q;
    logic [1:0] stg_n;

    always_comb begin
      stg_n = {stg_q[0], async_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= 2'b00;
      else        stg_q <= stg_n;
    end

    assign sync_o[g] = stg_q[1];
  end

endmodule

// File: rtl/sgp_fifo.sv
module sgp_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    if (do_push) wp_n = (wp_q == LAST) ? '0 : wp_q + PW'(1);
    if (do_pop)  rp_n = (rp_q == LAST) ? '0 : rp_q + PW'(1);
    cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // Storage has no reset; the write pointer enables each entry.
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data_i;
  end

endmodule

// File: rtl/sgp_frame_engine.sv
module sgp_frame_engine
  import sgp_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int SHORT_W = 12,
  parameter int LEN_W   = 6,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  frm_sel_e           frm_sel_i,
  input  ser_smp_t           smp_i,
  input  logic               rx_full_i,
  output logic               rx_push_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               rise_o,
  output logic               fall_o,
  output logic               start_o,
  output logic [CNT_W-1:0]   frame_len_o,
  output logic [LEN_W-1:0]   meas_len_o,
  output logic               meas_valid_o,
  output logic               short_o,
  output logic               ovf_o
);

  localparam logic [LEN_W-1:0] RUN_MAX = '1;

  logic               sck_d_q, sck_d_n;
  logic               ld_d_q, ld_d_n;
  logic               in_frm_q, in_frm_n;
  logic               done_q, done_n;
  logic [CNT_W-1:0]   bit_cnt_q, bit_cnt_n;
  logic [FRAME_W-1:0] shreg_q, shreg_n;
  logic [LEN_W-1:0]   run_q, run_n;
  logic [LEN_W-1:0]   meas_q, meas_n;
  logic               seen_q, seen_n;
  logic               valid_q, valid_n;
  logic               short_q, short_n;
  logic               ovf_q, ovf_n;
  logic               push_req;
  logic [FRAME_W-1:0] push_word;
  logic [CNT_W-1:0]   frame_len;
  logic               sck_rise, sck_fall, ld_edge;

  // Edge detection on the synchronized serial clock and load line
  always_comb begin
    frame_len = (frm_sel_i == FRM_LONG) ? CNT_W'(FRAME_W) : CNT_W'(SHORT_W);
    sck_rise  = smp_i.sck & ~sck_d_q;
    sck_fall  = ~smp_i.sck & sck_d_q;
    ld_edge   = en_i & sck_rise & smp_i.ld & ~ld_d_q;
  end

  // Next-state logic
  always_comb begin
    sck_d_n   = smp_i.sck;
    ld_d_n    = ld_d_q;
    in_frm_n  = in_frm_q;
    done_n    = done_q;
    bit_cnt_n = bit_cnt_q;
    shreg_n   = shreg_q;
    run_n     = run_q;
    meas_n    = meas_q;
    seen_n    = seen_q;
    valid_n   = valid_q;
    short_n   = short_q;
    ovf_n     = ovf_q;
    push_req  = 1'b0;
    push_word = shreg_q;

    if (!en_i) begin
      ld_d_n    = 1'b0;
      in_frm_n  = 1'b0;
      done_n    = 1'b0;
      bit_cnt_n = '0;
      shreg_n   = '0;
      run_n     = '0;
      meas_n    = '0;
      seen_n    = 1'b0;
      valid_n   = 1'b0;
      short_n   = 1'b0;
      ovf_n     = 1'b0;
    end else if (sck_rise) begin
      ld_d_n = smp_i.ld;
      run_n  = (run_q == RUN_MAX) ? run_q : run_q + LEN_W'(1);
      if (ld_edge) begin
        // Close an unfinished frame as a short one
        if (in_frm_q && !done_q) begin
          push_req  = 1'b1;
          push_word = shreg_q;
          short_n   = 1'b1;
        end
        if (seen_q) begin
          meas_n  = run_q;
          valid_n = 1'b1;
        end
        seen_n     = 1'b1;
        run_n      = LEN_W'(1);
        shreg_n    = '0;
        shreg_n[0] = smp_i.dat;
        bit_cnt_n  = CNT_W'(1);
        in_frm_n   = 1'b1;
        done_n     = 1'b0;
      end else if (in_frm_q && !done_q && (bit_cnt_q < CNT_W'(FRAME_W))) begin
        shreg_n[bit_cnt_q] = smp_i.dat;
        bit_cnt_n          = bit_cnt_q + CNT_W'(1);
        if ((bit_cnt_q + CNT_W'(1)) == frame_len) begin
          push_req  = 1'b1;
          push_word = shreg_n;
          done_n    = 1'b1;
        end
      end
    end

    if (en_i && push_req && rx_full_i) ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q   <= 1'b0;
      ld_d_q    <= 1'b0;
      in_frm_q  <= 1'b0;
      done_q    <= 1'b0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      run_q     <= '0;
      meas_q    <= '0;
      seen_q    <= 1'b0;
      valid_q   <= 1'b0;
      short_q   <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      sck_d_q   <= sck_d_n;
      ld_d_q    <= ld_d_n;
      in_frm_q  <= in_frm_n;
      done_q    <= done_n;
      bit_cnt_q <= bit_cnt_n;
      shreg_q   <= shreg_n;
      run_q     <= run_n;
      meas_q    <= meas_n;
      seen_q    <= seen_n;
      valid_q   <= valid_n;
      short_q   <= short_n;
      ovf_q     <= ovf_n;
    end
  end

  assign rx_push_o    = push_req & ~rx_full_i;
  assign rx_word_o    = push_word;
  assign rise_o       = sck_rise;
  assign fall_o       = sck_fall;
  assign start_o      = ld_edge;
  assign frame_len_o  = frame_len;
  assign meas_len_o   = meas_q;
  assign meas_valid_o = valid_q;
  assign short_o      = short_q;
  assign ovf_o        = ovf_q;

endmodule

// File: rtl/sgp_tx_serializer.sv
module sgp_tx_serializer #(
  parameter int FRAME_W = 24,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   frame_len_i,
  input  logic               tx_empty_i,
  input  logic [FRAME_W-1:0] tx_head_i,
  output logic               tx_pop_o,
  output logic               din_o
);

  logic [FRAME_W-1:0] word_q, word_n;
  logic [CNT_W-1:0]   idx_q, idx_n;
  logic               act_q, act_n;
  logic               din_q, din_n;

  always_comb begin
    word_n   = word_q;
    idx_n    = idx_q;
    act_n    = act_q;
    din_n    = din_q;
    tx_pop_o = 1'b0;

    if (!en_i) begin
      word_n = '0;
      idx_n  = '0;
      act_n  = 1'b0;
      din_n  = 1'b0;
    end else begin
      if (start_i) begin
        // Empty transmit FIFO: send an all-zero frame
        word_n   = tx_empty_i ? '0 : tx_head_i;
        tx_pop_o = ~tx_empty_i;
        idx_n    = '0;
        act_n    = 1'b1;
      end else if (rise_i && act_q && (idx_q < frame_len_i)) begin
        idx_n = idx_q + CNT_W'(1);
      end
      if (fall_i) begin
        din_n = (act_q && (idx_q < frame_len_i)) ? word_q[idx_q] : 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
      din_q  <= 1'b0;
    end else begin
      word_q <= word_n;
      idx_q  <= idx_n;
      act_q  <= act_n;
      din_q  <= din_n;
    end
  end

  assign din_o = din_q;

endmodule

// File: rtl/sgp_target_rx.sv
module sgp_target_rx
  import sgp_pkg::*;
#(
  parameter int FRAME_W  = 24,
  parameter int SHORT_W  = 12,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 4,
  parameter int LEN_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               cfg_long_i,
  input  logic               ser_clk_i,
  input  logic               ser_load_i,
  input  logic               ser_dout_i,
  output logic               ser_din_o,
  input  logic               rx_rd_i,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_empty_o,
  output logic               rx_full_o,
  input  logic               tx_wr_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_full_o,
  output logic [LEN_W-1:0]   meas_len_o,
  output logic               meas_valid_o,
  output logic               short_o,
  output logic               ovf_o
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int SMP_W = $bits(ser_smp_t);

  logic [SMP_W-1:0]   smp_bus;
  ser_smp_t           smp;
  frm_sel_e           frm_sel;
  logic               rx_push;
  logic [FRAME_W-1:0] rx_word;
  logic               sck_rise, sck_fall, frm_start;
  logic [CNT_W-1:0]   frame_len;
  logic               tx_pop, tx_empty;
  logic [FRAME_W-1:0] tx_head;

  assign frm_sel = frm_sel_e'(cfg_long_i);
  assign smp     = ser_smp_t'(smp_bus);

  sgp_sync #(.W(SMP_W)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_clk_i, ser_load_i, ser_dout_i}),
    .sync_o  (smp_bus)
  );

  sgp_frame_engine #(
    .FRAME_W (FRAME_W),
    .SHORT_W (SHORT_W),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W)
  ) eng_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .frm_sel_i    (frm_sel),
    .smp_i        (smp),
    .rx_full_i    (rx_full_o),
    .rx_push_o    (rx_push),
    .rx_word_o    (rx_word),
    .rise_o       (sck_rise),
    .fall_o       (sck_fall),
    .start_o      (frm_start),
    .frame_len_o  (frame_len),
    .meas_len_o   (meas_len_o),
    .meas_valid_o (meas_valid_o),
    .short_o      (short_o),
    .ovf_o        (ovf_o)
  );

  sgp_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) rx_fifo_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (rx_push),
    .push_data_i (rx_word),
    .pop_i       (rx_rd_i),
    .head_o      (rx_data_o),
    .empty_o     (rx_empty_o),
    .full_o      (rx_full_o)
  );

  sgp_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) tx_fifo_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (tx_wr_i),
    .push_data_i (tx_data_i),
    .pop_i       (tx_pop),
    .head_o      (tx_head),
    .empty_o     (tx_empty),
    .full_o      (tx_full_o)
  );

  sgp_tx_serializer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) ser_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .rise_i      (sck_rise),
    .fall_i      (sck_fall),
    .start_i     (frm_start),
    .frame_len_i (frame_len),
    .tx_empty_i  (tx_empty),
    .tx_head_i   (tx_head),
    .tx_pop_o    (tx_pop),
    .din_o       (ser_din_o)
  );

endmodule

// File: rtl/sgp_target_rx_chk.sv
module sgp_target_rx_chk #(
  parameter int FRAME_W = 24,
  parameter int SHORT_W = 12,
  parameter int LEN_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_i,
  input logic               cfg_long_i,
  input logic               rx_push,
  input logic [FRAME_W-1:0] rx_word,
  input logic               rx_full_o,
  input logic               rx_empty_o,
  input logic               meas_valid_o,
  input logic [LEN_W-1:0]   meas_len_o,
  input logic               short_o,
  input logic               ovf_o,
  input logic               ser_din_o
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full_o); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && en_i) |=> ovf_o); // R7

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (short_o && en_i) |=> short_o); // R6

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !cfg_long_i) |-> (rx_word[FRAME_W-1:SHORT_W] == '0)); // R5

  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!meas_valid_o && !short_o && !ovf_o && !ser_din_o)); // R11

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid_o && en_i) |=> meas_valid_o); // R4

  AST_MEAS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid_o |-> (meas_len_o != '0)); // R4

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full_o && rx_empty_o)); // R8

endmodule

bind sgp_target_rx sgp_target_rx_chk #(
  .FRAME_W (FRAME_W),
  .SHORT_W (SHORT_W),
  .LEN_W   (LEN_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .cfg_long_i   (cfg_long_i),
  .rx_push      (rx_push),
  .rx_word      (rx_word),
  .rx_full_o    (rx_full_o),
  .rx_empty_o   (rx_empty_o),
  .meas_valid_o (meas_valid_o),
  .meas_len_o   (meas_len_o),
  .short_o      (short_o),
  .ovf_o        (ovf_o),
  .ser_din_o    (ser_din_o)
);

// File: tb/sgp_target_rx_tb_top.sv
module sgp_target_rx_tb_top;

  localparam int FW  = 24;
  localparam int DEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cfg_long = 1'b0;
  logic sck = 1'b0, sld = 1'b0, sdo = 1'b0;
  logic rx_rd = 1'b0, tx_wr = 1'b0;
  logic [FW-1:0] tx_data = '0;
  logic ser_din_o, rx_empty_o, rx_full_o, tx_full_o, meas_valid_o, short_o, ovf_o;
  logic [FW-1:0] rx_data_o;
  logic [5:0] meas_len_o;

  always #10 clk = ~clk;

  sgp_target_rx dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .cfg_long_i(cfg_long),
    .ser_clk_i(sck), .ser_load_i(sld), .ser_dout_i(sdo), .ser_din_o(ser_din_o),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data_o), .rx_empty_o(rx_empty_o), .rx_full_o(rx_full_o),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_full_o(tx_full_o),
    .meas_len_o(meas_len_o), .meas_valid_o(meas_valid_o), .short_o(short_o), .ovf_o(ovf_o)
  );

  int n_chk = 0, n_bad = 0;
  bit sync_ok = 0;

  // Behavioural reference state
  bit m_en = 0, m_prev = 0, m_in = 0, m_done = 0;
  bit m_seen = 0, m_valid = 0, m_short = 0, m_ovf = 0, m_txact = 0;
  int m_cnt = 0, m_run = 0, m_len = 0, m_txi = 0;
  logic [FW-1:0] m_word = '0, m_txw = '0;
  logic [FW-1:0] rq[$];
  logic [FW-1:0] tq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int flen();
    return cfg_long ? 24 : 12;
  endfunction

  task automatic m_push(input logic [FW-1:0] w);
    if (rq.size() == DEP) m_ovf = 1;
    else rq.push_back(w);
  endtask

  task automatic m_clear();
    m_prev = 0; m_in = 0; m_done = 0; m_seen = 0; m_valid = 0;
    m_short = 0; m_ovf = 0; m_txact = 0; m_cnt = 0; m_run = 0; m_len = 0;
    m_txi = 0; m_word = '0; m_txw = '0;
  endtask

  task automatic m_rise(input bit ld, input bit d);
    bit start;
    if (!m_en) return;
    start = ld && !m_prev;
    m_prev = ld;
    if (start) begin
      if (m_in && !m_done) begin m_push(m_word); m_short = 1; end
      if (m_seen) begin m_len = m_run; m_valid = 1; end
      m_seen = 1; m_run = 1;
      m_word = '0; m_word[0] = d; m_cnt = 1; m_in = 1; m_done = 0;
      m_txw = (tq.size() > 0) ? tq.pop_front() : '0;
      m_txi = 0; m_txact = 1;
    end else begin
      if (m_run < 63) m_run++;
      if (m_in && !m_done) begin
        m_word[m_cnt] = d; m_cnt++;
        if (m_cnt == flen()) begin m_push(m_word); m_done = 1; end
      end
      if (m_txact && m_txi < flen()) m_txi++;
    end
  endtask

  // One serial clock period: 4 system clocks high, 4 low
  task automatic ser_bit(input bit ld, input bit d, input string req);
    logic exp;
    @(negedge clk); sck = 1; sld = ld; sdo = d; sync_ok = 0;
    repeat (4) @(negedge clk);
    m_rise(ld, d); sync_ok = 1;
    sck = 0;
    repeat (4) @(negedge clk);
    exp = (m_en && m_txact && m_txi < flen()) ? m_txw[m_txi] : 1'b0;
    chk(ser_din_o === exp, req, "ser_din_o bit", 32'(ser_din_o), 32'(exp));
  endtask

  task automatic send_frame(input int n, input logic [FW-1:0] w, input string req);
    for (int i = 0; i < n; i++) ser_bit(i == 0, w[i], req);
  endtask

  task automatic rx_pop(input logic [FW-1:0] exp, input string req);
    @(negedge clk);
    chk(rx_empty_o === 1'b0, req, "rx_empty_o before read", 32'(rx_empty_o), 0);
    chk(rx_data_o === exp, req, "rx_data_o", 32'(rx_data_o), 32'(exp));
    rx_rd = 1;
    if (rq.size() > 0) void'(rq.pop_front());
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic tx_push(input logic [FW-1:0] w);
    @(negedge clk); tx_wr = 1; tx_data = w; tq.push_back(w);
    @(negedge clk); tx_wr = 0;
  endtask

  // Per-clock comparison against the reference, away from the clock edge
  always @(posedge clk) begin
    #5;
    if (sync_ok) begin
      chk(rx_empty_o === (rq.size() == 0), "R8", "rx_empty_o", 32'(rx_empty_o), 32'(rq.size() == 0));
      chk(rx_full_o === (rq.size() == DEP), "R8", "rx_full_o", 32'(rx_full_o), 32'(rq.size() == DEP));
      chk(short_o === m_short, "R6", "short_o", 32'(short_o), 32'(m_short));
      chk(ovf_o === m_ovf, "R7", "ovf_o", 32'(ovf_o), 32'(m_ovf));
      chk(meas_valid_o === m_valid, "R4", "meas_valid_o", 32'(meas_valid_o), 32'(m_valid));
      if (m_valid)
        chk(meas_len_o === 6'(m_len), "R4", "meas_len_o", 32'(meas_len_o), 32'(m_len));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout act=%0d exp=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rx_empty_o === 1'b1 && meas_valid_o === 1'b0, "R1", "idle in reset",
        {rx_empty_o, meas_valid_o}, 2'b10);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(rx_empty_o === 1'b1, "R1", "rx_empty_o", 32'(rx_empty_o), 1);
    chk(rx_full_o === 1'b0, "R1", "rx_full_o", 32'(rx_full_o), 0);
    chk({short_o, ovf_o, meas_valid_o, ser_din_o} === 4'b0, "R1", "flags",
        {short_o, ovf_o, meas_valid_o, ser_din_o}, 0);
    en = 1; m_en = 1; sync_ok = 1;

    // 12-bit frames, bit order and measured length
    send_frame(12, 24'h000A5C, "R3");
    send_frame(12, 24'h0003C6, "R2");
    chk(meas_valid_o === 1'b1 && meas_len_o === 6'd12, "R4", "length 12",
        32'(meas_len_o), 12);
    rx_pop(24'h000A5C, "R3");
    rx_pop(24'h0003C6, "R5");

    // Surplus bits after a complete frame
    send_frame(14, 24'h003123, "R12");
    send_frame(12, 24'h000FFF, "R2");
    chk(meas_len_o === 6'd14, "R4", "length 14", 32'(meas_len_o), 14);
    rx_pop(24'h000123, "R12");
    rx_pop(24'h000FFF, "R2");

    // 24-bit frames
    @(negedge clk); cfg_long = 1;
    send_frame(24, 24'hC3A591, "R2");
    send_frame(24, 24'h5A0F7E, "R2");
    chk(meas_len_o === 6'd24, "R4", "length 24", 32'(meas_len_o), 24);
    rx_pop(24'hC3A591, "R2");
    rx_pop(24'h5A0F7E, "R3");

    // 12-bit frames with 24-bit size configured
    send_frame(12, 24'h000B2D, "R6");
    send_frame(12, 24'h0004E1, "R6");
    chk(short_o === 1'b1, "R6", "short_o set", 32'(short_o), 1);
    chk(meas_len_o === 6'd12, "R4", "measured short", 32'(meas_len_o), 12);
    send_frame(24, 24'h13579B, "R6");
    rx_pop(24'h000B2D, "R5");
    rx_pop(24'h0004E1, "R5");
    rx_pop(24'h13579B, "R2");

    // Disable clears and ignores serial activity
    @(negedge clk); en = 0; m_en = 0; m_clear();
    repeat (2) @(negedge clk);
    chk({short_o, meas_valid_o, ovf_o} === 3'b0, "R11", "flags cleared",
        {short_o, meas_valid_o, ovf_o}, 0);
    @(negedge clk); cfg_long = 0;
    send_frame(12, 24'h000777, "R11");
    chk(rx_empty_o === 1'b1, "R11", "nothing stored", 32'(rx_empty_o), 1);
    @(negedge clk); en = 1; m_en = 1;

    // Transmit path
    tx_push(24'h0009C3);
    tx_push(24'h0005A6);
    send_frame(12, 24'h000111, "R9");
    send_frame(12, 24'h000222, "R9");
    send_frame(12, 24'h000333, "R10");
    chk(ser_din_o === 1'b0, "R10", "din idle zero", 32'(ser_din_o), 0);
    rx_pop(24'h000111, "R8");
    rx_pop(24'h000222, "R8");
    rx_pop(24'h000333, "R8");

    // Overflow on a full receive FIFO
    send_frame(12, 24'h000101, "R8");
    send_frame(12, 24'h000202, "R8");
    send_frame(12, 24'h000303, "R8");
    send_frame(12, 24'h000404, "R8");
    chk(rx_full_o === 1'b1 && ovf_o === 1'b0, "R8", "full, no overflow yet",
        {rx_full_o, ovf_o}, 2'b10);
    send_frame(12, 24'h000505, "R7");
    chk(ovf_o === 1'b1, "R7", "ovf_o set", 32'(ovf_o), 1);
    rx_pop(24'h000101, "R7");
    rx_pop(24'h000202, "R8");
    rx_pop(24'h000303, "R8");
    rx_pop(24'h000404, "R7");
    @(negedge clk);
    chk(rx_empty_o === 1'b1, "R7", "dropped frame absent", 32'(rx_empty_o), 1);
    chk(ovf_o === 1'b1, "R7", "ovf_o sticky", 32'(ovf_o), 1);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule